// File: doc/BRIEF.md
# Shadow-Select Dual-Channel Task File Front End

This block is the host-facing register front end for two ATA-style task file register sets, a master and a slave, that share one legacy window of two 32-bit words. Each host access carries byte enables, and every enabled byte lane maps to one task file register. A hidden shadow select bit decides which channel the legacy window reaches. The bit is reloaded whenever the host writes the Device+Head byte. That write is itself routed by the select bit it carries, not by the bit already held.

A second register space exposes each channel's two words directly at a fixed alias location per channel. The alias ignores the shadow bit. The device side is reduced to per-channel status and error bytes that appear on reads. A command byte write produces a one-cycle strobe and a held command code per channel. The Features byte written by the host is brought out per channel.

Top module: `tfs_front`

## Requirements
- R1: After reset, every stored task file byte of both channels is 0, `shadow_sel` is 0 (master), `cmd_strobe` is 0 and `features` is 0.
- R2: Word 0 (legacy offset 0x000) lanes: lane 0 (bits 7:0) is Data, lane 2 (bits 23:16) is Sector Count and lane 3 (bits 31:24) is Starting Sector Number. Each is written and read back at that lane.
- R3: Lane 1 of word 0 is split. A write stores the Features byte, seen on `features[8c+7:8c]` for channel c. A read returns `dev_error[8c+7:8c]` of the channel addressed.
- R4: Word 1 (legacy offset 0x004) lanes: lane 0 is Cylinder Low, lane 1 is Cylinder High and lane 2 is Device+Head, all read back as stored. A read of lane 3 returns `dev_status[8c+7:8c]`.
- R5: Legacy accesses other than a Device+Head write go to channel 0 when `shadow_sel` is 0 and to channel 1 when it is 1.
- R6: A legacy write to word 1 with lane 2 enabled loads `shadow_sel` from `wdata[20]` (bit 4 of the Device+Head byte) at that clock edge. The whole access, all enabled lanes, goes to the channel named by `wdata[20]`.
- R7: Stored Device+Head always holds 0 in its bit 4, so a read of lane 2 of word 1 shows bit 20 as 0.
- R8: A write to lane 3 of word 1 sets `cmd_code[8c+7:8c]` of the target channel and drives `cmd_strobe[c]` high for exactly the one cycle after the write edge.
- R9: In the alias space (`alias_sp`=1), channel c word w sits at address 0x080 + c*0x100 + 4*w. Alias accesses ignore `shadow_sel` and never change it. Alias Device+Head writes also store bit 4 as 0.
- R10: Only lanes whose byte enable is set are written. Read lanes whose enable is clear return 0.
- R11: Accesses to any other address change no state, and their reads return 0. `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| alias_sp | input | 1 | 0: legacy window, 1: alias space |
| addr | input | 10 | Byte address of the word |
| be | input | 4 | Byte lane enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the same-cycle request |
| dev_status | input | 16 | Device status byte per channel |
| dev_error | input | 16 | Device error byte per channel |
| shadow_sel | output | 1 | Current shadow select (0 master, 1 slave) |
| cmd_strobe | output | 2 | One-cycle command write pulse per channel |
| cmd_code | output | 16 | Last command byte per channel |
| features | output | 16 | Last Features byte per channel |

## Verification
Full-word writes and reads of both words show the lane map and the read/write split of the shared bytes. Device+Head writes made with bit 4 opposite to the current shadow bit show whether steering uses the carried bit or the held bit. Multi-lane words that include Device+Head show that the whole access follows that bit. Single-lane writes and reads show the byte-enable masking. Alias writes, unmapped addresses, and legacy addresses presented in alias space show that neither the shadow bit nor other state is disturbed.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
   localparam int LANE_W   = 8;
   localparam int LANES    = 4;
   localparam int WORD_W   = LANE_W * LANES;
   localparam int NCH      = 2;
   // word 0 lanes
   localparam int LN_DATA  = 0;
   localparam int LN_FEAT  = 1;
   localparam int LN_SCNT  = 2;
   localparam int LN_SNUM  = 3;
   // word 1 lanes
   localparam int LN_CYLL  = 0;
   localparam int LN_CYLH  = 1;
   localparam int LN_DEVH  = 2;
   localparam int LN_CMD   = 3;
   // device select bit within the Device+Head byte
   localparam int SEL_BIT  = 4;
   localparam int SEL_POS  = LN_DEVH * LANE_W + SEL_BIT;

   typedef struct packed {
      logic hit;
      logic word;
      logic ch;
   } tfs_route_t;
endpackage

// File: rtl/tfs_route.sv
module tfs_route
   import tfs_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int ALIAS_BASE = 'h080,
   parameter int CH_STRIDE  = 'h100
) (
   input  logic              alias_sp,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_wr,
   input  logic [LANES-1:0]  be,
   input  logic              dh_bit,
   input  logic              shadow,
   output tfs_route_t        route
);
   localparam int TOP_ADDR = ALIAS_BASE + (NCH - 1) * CH_STRIDE + 4;

   generate
      if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("alias window does not fit in ADDR_W");
      end
      if (CH_STRIDE < 8) begin : g_bad_stride
         $error("CH_STRIDE must leave room for two words");
      end
   endgenerate

   logic [NCH-1:0] al_w0, al_w1;

   for (genvar c = 0; c < NCH; c++) begin : g_alias
      assign al_w0[c] = (addr == ADDR_W'(ALIAS_BASE + c * CH_STRIDE));
      assign al_w1[c] = (addr == ADDR_W'(ALIAS_BASE + c * CH_STRIDE + 4));
   end

   logic leg_w0, leg_w1;
   assign leg_w0 = (addr == ADDR_W'(0));
   assign leg_w1 = (addr == ADDR_W'(4));

   always_comb begin
      route = '0;
      if (!alias_sp) begin
         route.hit  = leg_w0 | leg_w1;
         route.word = leg_w1;
         if (leg_w1 && is_wr && be[LN_DEVH]) route.ch = dh_bit;
         else                                route.ch = shadow;
      end else begin
         route.hit  = |(al_w0 | al_w1);
         route.word = |al_w1;
         route.ch   = al_w0[1] | al_w1[1];
      end
   end
endmodule

// File: rtl/tfs_chan_regs.sv
module tfs_chan_regs
   import tfs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_w0,
   input  logic              wr_w1,
   input  logic [LANES-1:0]  be,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] word0_q,
   output logic [WORD_W-1:0] word1_q,
   output logic              cmd_pulse
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] w1_in;
      if (l == LN_DEVH) begin : g_dh
         always_comb begin
            w1_in          = wdata[l*LANE_W +: LANE_W];
            w1_in[SEL_BIT] = 1'b0;
         end
      end else begin : g_plain
         assign w1_in = wdata[l*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word0_q[l*LANE_W +: LANE_W] <= '0;
            word1_q[l*LANE_W +: LANE_W] <= '0;
         end else begin
            if (wr_w0 && be[l]) word0_q[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            if (wr_w1 && be[l]) word1_q[l*LANE_W +: LANE_W] <= w1_in;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_pulse <= 1'b0;
      else        cmd_pulse <= wr_w1 && be[LN_CMD];
   end

   // R8: a pulse only follows a command-lane write
   a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse |-> $past(wr_w1 && be[LN_CMD]));
   // R10: an idle word keeps its contents
   a_r10_word0_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_w0 |=> $stable(word0_q));
endmodule

// File: rtl/tfs_front.sv
module tfs_front
   import tfs_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int ALIAS_BASE = 'h080,
   parameter int CH_STRIDE  = 'h100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic                  alias_sp,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [LANES-1:0]      be,
   input  logic [WORD_W-1:0]     wdata,
   output logic [WORD_W-1:0]     rdata,
   input  logic [NCH*LANE_W-1:0] dev_status,
   input  logic [NCH*LANE_W-1:0] dev_error,
   output logic                  shadow_sel,
   output logic [NCH-1:0]        cmd_strobe,
   output logic [NCH*LANE_W-1:0] cmd_code,
   output logic [NCH*LANE_W-1:0] features
);
   generate
      if (ADDR_W < 4) begin : g_bad_aw
         $error("ADDR_W too small for the legacy window");
      end
   endgenerate

   tfs_route_t route;

   tfs_route #(
      .ADDR_W    (ADDR_W),
      .ALIAS_BASE(ALIAS_BASE),
      .CH_STRIDE (CH_STRIDE)
   ) u_route (
      .alias_sp(alias_sp),
      .addr    (addr),
      .is_wr   (wr_en),
      .be      (be),
      .dh_bit  (wdata[SEL_POS]),
      .shadow  (shadow_sel),
      .route   (route)
   );

   logic [NCH-1:0][WORD_W-1:0] w0_q, w1_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel_c;
      assign sel_c = wr_en && route.hit && (route.ch == 1'(c));

      tfs_chan_regs u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_w0    (sel_c && !route.word),
         .wr_w1    (sel_c &&  route.word),
         .be       (be),
         .wdata    (wdata),
         .word0_q  (w0_q[c]),
         .word1_q  (w1_q[c]),
         .cmd_pulse(cmd_strobe[c])
      );

      assign features[c*LANE_W +: LANE_W] = w0_q[c][LN_FEAT*LANE_W +: LANE_W];
      assign cmd_code[c*LANE_W +: LANE_W] = w1_q[c][LN_CMD*LANE_W +: LANE_W];
   end

   // shadow select register
   always_ff @(posedge clk) begin
      if (!rst_n) shadow_sel <= 1'b0;
      else if (wr_en && !alias_sp && route.hit && route.word && be[LN_DEVH])
         shadow_sel <= wdata[SEL_POS];
   end

   // read path
   logic [WORD_W-1:0] rd_word;
   always_comb begin
      if (!route.word) begin
         rd_word = w0_q[route.ch];
         rd_word[LN_FEAT*LANE_W +: LANE_W] = dev_error[route.ch*LANE_W +: LANE_W];
      end else begin
         rd_word = w1_q[route.ch];
         rd_word[LN_CMD*LANE_W +: LANE_W]  = dev_status[route.ch*LANE_W +: LANE_W];
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rlane
      assign rdata[l*LANE_W +: LANE_W] =
         (rd_en && route.hit && be[l]) ? rd_word[l*LANE_W +: LANE_W] : '0;
   end

   // R6: Device+Head write loads the shadow bit from the written bit 4
   a_r6_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !alias_sp && addr == ADDR_W'(4) && be[LN_DEVH])
      |=> shadow_sel == $past(wdata[SEL_POS]));
   // R9: any other access leaves the shadow bit alone
   a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !alias_sp && addr == ADDR_W'(4) && be[LN_DEVH]) |=> $stable(shadow_sel));
   // R8: at most one channel strobes per cycle
   a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_strobe));
   // R8: a legacy command write strobes some channel next cycle
   a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !alias_sp && addr == ADDR_W'(4) && be[LN_CMD]) |=> (cmd_strobe != '0));
   // R11: idle read port returns zero
   a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));
endmodule

// File: tb/tfs_front_test.sv
module tfs_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, alias_sp = 1'b0;
   logic [9:0]  addr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] dev_status = {8'h58, 8'h50};
   logic [15:0] dev_error  = {8'hE2, 8'hE1};
   logic        shadow_sel;
   logic [1:0]  cmd_strobe;
   logic [15:0] cmd_code, features;

   int errors = 0, checks = 0;
   logic [1:0] strobe_seen;

   always #2 clk = ~clk;

   tfs_front uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .alias_sp(alias_sp),
      .addr(addr), .be(be), .wdata(wdata), .rdata(rdata),
      .dev_status(dev_status), .dev_error(dev_error), .shadow_sel(shadow_sel),
      .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .features(features)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic sp, input logic [9:0] a, input logic [3:0] b, input logic [31:0] d);
      @(negedge clk);
      alias_sp = sp; addr = a; be = b; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; be = '0; wdata = '0; alias_sp = 1'b0; addr = '0;
      strobe_seen = cmd_strobe;
   endtask

   task automatic rd(input logic sp, input logic [9:0] a, input logic [3:0] b, output logic [31:0] d);
      @(negedge clk);
      alias_sp = sp; addr = a; be = b; rd_en = 1'b1;
      #1 d = rdata;
      rd_en = 1'b0; be = '0; alias_sp = 1'b0; addr = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(0, 10'h000, 4'hF, d); chk("R1 word0 reset", d, 32'h0000_E100);
      rd(0, 10'h004, 4'hF, d); chk("R1 word1 reset", d, 32'h5000_0000);
      chk("R1 shadow reset", 32'(shadow_sel), 0);
      chk("R1 strobe reset", 32'(cmd_strobe), 0);
      chk("R1 features reset", 32'(features), 0);
   endtask

   task automatic t_word0;
      logic [31:0] d;
      wr(0, 10'h000, 4'hF, 32'h4433_2211);
      rd(0, 10'h000, 4'hF, d); chk("R2 R3 word0 lanes", d, 32'h4433_E111);
      chk("R3 features master", 32'(features), 32'h0000_0022);
   endtask

   task automatic t_steer;
      logic [31:0] d;
      wr(0, 10'h004, 4'b0100, 32'h00F5_0000);
      chk("R6 shadow to slave", 32'(shadow_sel), 1);
      rd(0, 10'h004, 4'hF, d); chk("R7 R4 slave word1", d, 32'h58E5_0000);
      rd(0, 10'h000, 4'hF, d); chk("R5 slave word0 error", d, 32'h0000_E200);
      wr(0, 10'h004, 4'b0111, 32'h00A0_2211);
      chk("R6 shadow to master", 32'(shadow_sel), 0);
      rd(0, 10'h004, 4'hF, d); chk("R6 R4 master word1", d, 32'h50A0_2211);
      rd(1, 10'h184, 4'hF, d); chk("R6 slave untouched", d, 32'h58E5_0000);
   endtask

   task automatic t_cmd;
      logic [31:0] d;
      wr(0, 10'h004, 4'b1000, 32'hEC00_0000);
      chk("R8 strobe master", 32'(strobe_seen), 1);
      chk("R8 code master", 32'(cmd_code), 32'h0000_00EC);
      @(negedge clk);
      chk("R8 strobe one cycle", 32'(cmd_strobe), 0);
      rd(0, 10'h004, 4'hF, d); chk("R4 status on read", d, 32'h50A0_2211);
   endtask

   task automatic t_alias;
      logic [31:0] d;
      wr(1, 10'h180, 4'hF, 32'h0D0C_0B0A);
      chk("R9 alias keeps shadow", 32'(shadow_sel), 0);
      rd(1, 10'h180, 4'hF, d); chk("R9 alias word0", d, 32'h0D0C_E20A);
      chk("R9 R3 features slave", 32'(features), 32'h0000_0B22);
      wr(1, 10'h184, 4'b0100, 32'h0050_0000);
      chk("R9 alias dh keeps shadow", 32'(shadow_sel), 0);
      rd(1, 10'h184, 4'hF, d); chk("R7 alias dh bit4", d, 32'h5840_0000);
      wr(1, 10'h184, 4'b1000, 32'h9100_0000);
      chk("R8 R9 alias strobe slave", 32'(strobe_seen), 2);
      chk("R8 code slave", 32'(cmd_code), 32'h0000_91EC);
      rd(0, 10'h000, 4'hF, d); chk("R9 master word0 intact", d, 32'h4433_E111);
   endtask

   task automatic t_lanes;
      logic [31:0] d;
      wr(0, 10'h000, 4'b0001, 32'hFFFF_FF99);
      rd(0, 10'h000, 4'hF, d); chk("R10 single lane write", d, 32'h4433_E199);
      rd(0, 10'h000, 4'b0010, d); chk("R10 single lane read", d, 32'h0000_E100);
      chk("R10 features unchanged", 32'(features), 32'h0000_0B22);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(0, 10'h008, 4'hF, 32'hDEAD_BEEF);
      rd(0, 10'h000, 4'hF, d); chk("R11 write ignored", d, 32'h4433_E199);
      chk("R11 features intact", 32'(features), 32'h0000_0B22);
      rd(0, 10'h008, 4'hF, d); chk("R11 unmapped read", d, 0);
      rd(1, 10'h188, 4'hF, d); chk("R11 alias gap read", d, 0);
      rd(0, 10'h080, 4'hF, d); chk("R11 alias addr in legacy", d, 0);
      rd(1, 10'h004, 4'hF, d); chk("R11 legacy addr in alias", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_word0;
      t_steer;
      t_cmd;
      t_alias;
      t_lanes;
      t_unmapped;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule